// File: doc/BRIEF.md
# Watch Timer with Buzzer and LCD Clock Outputs

This block divides a slow timekeeping clock, nominally 32,768 Hz, into three outputs that run at the same time. The first is a periodic interval request: a sticky flag that software polls or clears, rather than a vectored interrupt. The second is a square-wave buzzer tone. The third is a fixed-rate clock for an LCD controller. One free-running 14-bit divider feeds all three, so the interval, the tone and the LCD clock always stay in phase with one another.

The block runs on the system clock. The divider advances once for each single-cycle enable pulse from the selected source. That source is either the subsystem-clock tick or a tick from a divided main clock. An 8-bit mode register, written through a simple write strobe, sets the enable, the source, the interval length, the tone, and the output gates. The same write can clear the request flag through a write-one-to-clear bit that is not stored. When the tone or interval selection changes, the new choice takes effect only at the end of the running period, so neither output ever shows a truncated pulse.

Top module: `watch_timer`

## Requirements
- R1: After reset, the mode register reads as all zero, and `ivl_flag`, `buz_out` and `lcd_clk` are all 0.
- R2: While mode bit 0 (run) is 0, the divider is held at zero and `buz_out` and `lcd_clk` are 0. After bit 0 is set, the divider counts up from zero, so the first selected tick brings the count to 1.
- R3: Mode bit 1 selects the tick source: 0 counts `sub_tick` pulses and 1 counts `main_tick` pulses. Pulses on the unselected input have no effect on any output.
- R4: Mode bit 2 selects the interval. With bit 2 = 0 the flag is set on every 16384th tick after enabling (0.5 s at 32,768 Hz). With bit 2 = 1 it is set on every 128th tick (about 3.9 ms).
- R5: `ivl_flag` stays set until a mode write has bit 7 = 1. That write clears it in the same cycle as the write. Bit 7 is not stored, so later interval events set the flag again.
- R6: Mode bits 4:3 select the tone divisor D: code 0 gives D = 2, code 1 gives D = 4, code 2 gives D = 8 and code 3 gives D = 16. With n ticks counted since enabling, `buz_out` is 1 exactly when (n mod D) is at least D/2.
- R7: `lcd_clk` is a square wave at the tick rate divided by 64: it is 1 exactly when (n mod 64) is at least 32.
- R8: A change to the tone code takes effect only when the tone currently in use completes a full period, that is, when n reaches a multiple of its D. Until then the old tone continues.
- R9: A change to the interval selection takes effect only when the interval currently in use completes. Until then no event is taken from the newly requested interval.
- R10: Mode bit 5 gates the buzzer and bit 6 gates the LCD clock. When a gate bit is 0 its output is 0, while the divider keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | One-cycle count pulse from the subsystem clock |
| main_tick | input | 1 | One-cycle count pulse from the divided main clock |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode write data (bit 7 clears the request flag) |
| ivl_flag | output | 1 | Sticky interval request flag |
| buz_out | output | 1 | Buzzer square wave |
| lcd_clk | output | 1 | Clock for the LCD controller |

## Verification
The bench changes the tone from divide-by-16 to divide-by-2 partway through a period. A design that switched taps at once would toggle the buzzer out of phase, and would be caught before the period boundary. It requests the short interval while the long one is running and checks that no flag appears at tick 128. A design that applied the request immediately would raise the flag early. It also checks that clearing the flag does not stop the next event from setting it again. It sends pulses on the unselected source, which a design with a swapped source mux would count. Randomly chosen tones and run lengths then compare the phase of both square waves against the divisor formula from the moment of enabling. A design that did not restart from zero would fail these checks.

// File: rtl/wt_pkg.sv
package wt_pkg;

    localparam int WT_CNT_W  = 14;
    localparam int WT_TONE_W = 2;

    // Write view of the mode register, MSB first.
    typedef struct packed {
        logic                 clr;
        logic                 lcd_on;
        logic                 buz_on;
        logic [WT_TONE_W-1:0] tone;
        logic                 fast;
        logic                 src_main;
        logic                 run;
    } wt_mode_t;

    // Stored configuration; the clear bit is never kept.
    typedef struct packed {
        logic                 lcd_on;
        logic                 buz_on;
        logic [WT_TONE_W-1:0] tone;
        logic                 fast;
        logic                 src_main;
        logic                 run;
    } wt_cfg_t;

    function automatic wt_cfg_t wt_to_cfg(input wt_mode_t m);
        wt_cfg_t c;
        c.lcd_on   = m.lcd_on;
        c.buz_on   = m.buz_on;
        c.tone     = m.tone;
        c.fast     = m.fast;
        c.src_main = m.src_main;
        c.run      = m.run;
        return c;
    endfunction

endpackage

// File: rtl/wt_divider.sv
module wt_divider #(
    parameter int CNT_W = wt_pkg::WT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    a_r2_hold_zero: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt == '0);

    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        (en && tick) |=> cnt == $past(cnt) + CNT_W'(1));

endmodule

// File: rtl/wt_interval.sv
module wt_interval #(
    parameter int CNT_W     = wt_pkg::WT_CNT_W,
    parameter int LONG_LOG  = 14,
    parameter int SHORT_LOG = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             fast_req,
    input  logic             clr,
    output logic             flag
);

    logic act_fast;
    logic wrap_long;
    logic wrap_short;
    logic event_now;

    assign wrap_long  = &cnt[LONG_LOG-1:0];
    assign wrap_short = &cnt[SHORT_LOG-1:0];
    assign event_now  = en && tick && (act_fast ? wrap_short : wrap_long);

    // The selection is latched only at a completed interval.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_fast <= 1'b0;
        end else if (!en || event_now) begin
            act_fast <= fast_req;
        end
    end

    // Set has priority so an event coinciding with a clear is not lost.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (event_now) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    a_r4_flag_needs_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(en && tick));

    a_r5_flag_drop_on_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(clr));

    a_r9_ivl_switch_at_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_fast) |-> $past(!en || event_now));

endmodule

// File: rtl/wt_tone.sv
module wt_tone #(
    parameter int CNT_W = wt_pkg::WT_CNT_W,
    parameter int SEL_W = wt_pkg::WT_TONE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [SEL_W-1:0] sel_req,
    output logic             wave
);

    localparam int NTAP = 1 << SEL_W;

    logic [NTAP-1:0]  taps;
    logic [NTAP-1:0]  wraps;
    logic [SEL_W-1:0] act_sel;
    logic             period_end;

    // Tap g divides by 2^(g+1); its period ends when bits g..0 are all ones.
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign taps[g]  = cnt[g];
        assign wraps[g] = &cnt[g:0];
    end

    assign period_end = tick && wraps[act_sel];
    assign wave       = en && taps[act_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            act_sel <= '0;
        end else if (!en || period_end) begin
            act_sel <= sel_req;
        end
    end

    a_r8_tone_switch_at_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_sel) |-> $past(!en || period_end));

    a_r6_wave_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(wave)) |-> $past(tick));

endmodule

// File: rtl/watch_timer.sv
module watch_timer
    import wt_pkg::*;
#(
    parameter int CNT_W     = WT_CNT_W,
    parameter int LONG_LOG  = 14,
    parameter int SHORT_LOG = 7,
    parameter int LCD_LOG   = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sub_tick,
    input  logic       main_tick,
    input  logic       mode_we,
    input  logic [7:0] mode_wdata,
    output logic       ivl_flag,
    output logic       buz_out,
    output logic       lcd_clk
);

    wt_mode_t         wr_view;
    wt_cfg_t          cfg_q;
    logic             clr_pulse;
    logic             tick_sel;
    logic [CNT_W-1:0] cnt;
    logic             tone_wave;

    assign wr_view   = wt_mode_t'(mode_wdata);
    assign clr_pulse = mode_we && wr_view.clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (mode_we) begin
            cfg_q <= wt_to_cfg(wr_view);
        end
    end

    assign tick_sel = cfg_q.src_main ? main_tick : sub_tick;

    wt_divider #(.CNT_W(CNT_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (cfg_q.run),
        .tick (tick_sel),
        .cnt  (cnt)
    );

    wt_interval #(
        .CNT_W     (CNT_W),
        .LONG_LOG  (LONG_LOG),
        .SHORT_LOG (SHORT_LOG)
    ) u_ivl (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_q.run),
        .tick     (tick_sel),
        .cnt      (cnt),
        .fast_req (cfg_q.fast),
        .clr      (clr_pulse),
        .flag     (ivl_flag)
    );

    wt_tone #(.CNT_W(CNT_W), .SEL_W(WT_TONE_W)) u_tone (
        .clk     (clk),
        .rst     (rst),
        .en      (cfg_q.run),
        .tick    (tick_sel),
        .cnt     (cnt),
        .sel_req (cfg_q.tone),
        .wave    (tone_wave)
    );

    assign buz_out = tone_wave && cfg_q.buz_on;
    assign lcd_clk = cnt[LCD_LOG-1] && cfg_q.lcd_on && cfg_q.run;

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!ivl_flag && !buz_out && !lcd_clk));

endmodule

// File: tb/watch_timer_bench.sv
module watch_timer_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       sub_tick;
    logic       main_tick;
    logic       mode_we;
    logic [7:0] mode_wdata;
    logic       ivl_flag;
    logic       buz_out;
    logic       lcd_clk;

    int  checks = 0;
    int  errors = 0;
    int  n      = 0;
    bit  done   = 0;

    always #10 clk = ~clk;

    watch_timer u_watch_timer (
        .clk        (clk),
        .rst        (rst),
        .sub_tick   (sub_tick),
        .main_tick  (main_tick),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .ivl_flag   (ivl_flag),
        .buz_out    (buz_out),
        .lcd_clk    (lcd_clk)
    );

    function automatic bit sq(input int cnt, input int div);
        return (cnt % div) >= (div / 2);
    endfunction

    function automatic logic [7:0] md(input bit run, input bit src, input bit fast,
                                      input int tone, input bit buz, input bit lcd,
                                      input bit clr);
        logic [1:0] t = tone[1:0];
        return {clr, lcd, buz, t, fast, src, run};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d n=%0d", req, act, exp, n);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        mode_we    = 1'b1;
        mode_wdata = d;
        @(negedge clk);
        mode_we    = 1'b0;
    endtask

    task automatic tk(input bit use_main);
        @(negedge clk);
        if (use_main) main_tick = 1'b1;
        else          sub_tick  = 1'b1;
        @(negedge clk);
        sub_tick  = 1'b0;
        main_tick = 1'b0;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        bit saved;
        void'($urandom(32'd1234));
        rst = 1'b1; sub_tick = 0; main_tick = 0; mode_we = 0; mode_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(ivl_flag == 0, "R1 flag", ivl_flag, 0);
        check(buz_out == 0, "R1 buz", buz_out, 0);
        check(lcd_clk == 0, "R1 lcd", lcd_clk, 0);

        // R2 disabled: ticks have no effect, outputs stay low
        wr(md(0, 0, 0, 0, 1, 1, 0));
        for (int i = 0; i < 40; i++) begin
            tk(0);
            check(buz_out == 0 && lcd_clk == 0, "R2 held", buz_out, 0);
        end
        wr(md(1, 0, 0, 0, 1, 1, 0));
        n = 0;
        check(buz_out == 0, "R2 start at zero", buz_out, 0);
        for (int i = 0; i < 3; i++) begin
            tk(0); n++;
            check(buz_out == sq(n, 2), "R2 count from zero", buz_out, sq(n, 2));
        end

        // R3 source selection
        wr(md(1, 1, 0, 0, 1, 1, 0));
        for (int i = 0; i < 3; i++) begin
            tk(0);
            check(buz_out == sq(n, 2), "R3 sub ignored", buz_out, sq(n, 2));
        end
        tk(1); n++;
        check(buz_out == sq(n, 2), "R3 main counted", buz_out, sq(n, 2));

        // R6 R7 random tones and run lengths
        for (int it = 0; it < 24; it++) begin
            int tone = int'($urandom % 4);
            int len  = 1 + int'($urandom % 80);
            wr(md(0, 0, 0, tone, 1, 1, 0));
            wr(md(1, 0, 0, tone, 1, 1, 0));
            n = 0;
            for (int i = 0; i < len; i++) begin
                tk(0); n++;
                check(buz_out == sq(n, 2 << tone), "R6 tone phase", buz_out, sq(n, 2 << tone));
                check(lcd_clk == sq(n, 64), "R7 lcd phase", lcd_clk, sq(n, 64));
            end
        end

        // R10 output gates
        wr(md(0, 0, 0, 0, 0, 0, 0));
        wr(md(1, 0, 0, 0, 0, 0, 0));
        n = 0;
        for (int i = 0; i < 40; i++) begin
            tk(0); n++;
            check(buz_out == 0 && lcd_clk == 0, "R10 gated", buz_out | lcd_clk, 0);
        end
        wr(md(1, 0, 0, 0, 1, 1, 0));
        check(lcd_clk == sq(n, 64), "R10 divider kept counting", lcd_clk, sq(n, 64));

        // R8 tone change waits for period end
        wr(md(0, 0, 0, 3, 1, 1, 0));
        wr(md(1, 0, 0, 3, 1, 1, 0));
        n = 0;
        for (int i = 0; i < 5; i++) begin tk(0); n++; end
        wr(md(1, 0, 0, 0, 1, 1, 0));
        for (int i = 0; i < 10; i++) begin
            tk(0); n++;
            check(buz_out == sq(n, 16), "R8 old tone kept", buz_out, sq(n, 16));
        end
        for (int i = 0; i < 5; i++) begin
            tk(0); n++;
            check(buz_out == sq(n, 2), "R8 new tone", buz_out, sq(n, 2));
        end

        // R4 short interval, R5 sticky flag and clear
        wr(md(0, 0, 1, 0, 1, 1, 0));
        wr(md(1, 0, 1, 0, 1, 1, 0));
        n = 0;
        for (int i = 0; i < 127; i++) begin tk(0); n++; end
        check(ivl_flag == 0, "R4 before short interval", ivl_flag, 0);
        tk(0); n++;
        check(ivl_flag == 1, "R4 short interval", ivl_flag, 1);
        for (int i = 0; i < 5; i++) begin tk(0); n++; end
        check(ivl_flag == 1, "R5 sticky", ivl_flag, 1);
        wr(md(1, 0, 1, 0, 1, 1, 1));
        check(ivl_flag == 0, "R5 cleared", ivl_flag, 0);
        while (n < 255) begin tk(0); n++; end
        check(ivl_flag == 0, "R5 stays clear", ivl_flag, 0);
        tk(0); n++;
        check(ivl_flag == 1, "R5 clear not stored", ivl_flag, 1);
        wr(md(1, 0, 1, 0, 1, 1, 1));

        // R9 interval change waits for long interval end
        wr(md(0, 0, 0, 0, 1, 1, 1));
        wr(md(1, 0, 0, 0, 1, 1, 0));
        n = 0;
        for (int i = 0; i < 100; i++) begin tk(0); n++; end
        wr(md(1, 0, 1, 0, 1, 1, 0));
        while (n < 128) begin tk(0); n++; end
        check(ivl_flag == 0, "R9 no early short event", ivl_flag, 0);
        while (n < 16383) begin tk(0); n++; end
        check(ivl_flag == 0, "R4 before long interval", ivl_flag, 0);
        tk(0); n++;
        check(ivl_flag == 1, "R4 long interval", ivl_flag, 1);
        wr(md(1, 0, 1, 0, 1, 1, 1));
        check(ivl_flag == 0, "R5 clear after long", ivl_flag, 0);
        for (int i = 0; i < 127; i++) begin tk(0); n++; end
        check(ivl_flag == 0, "R9 before new short", ivl_flag, 0);
        tk(0); n++;
        check(ivl_flag == 1, "R9 short applied", ivl_flag, 1);

        // R2 disabling forces outputs low
        saved = ivl_flag;
        wr(md(0, 0, 0, 0, 1, 1, 0));
        check(buz_out == 0 && lcd_clk == 0, "R2 disable low", buz_out | lcd_clk, 0);
        check(ivl_flag == saved, "R5 flag kept on disable", ivl_flag, saved);

        summary();
    end

endmodule